// File: doc/BRIEF.md
# Timeslot PRBS Test-Pattern Inserter

This block places a 2^15-1 pseudo-random test pattern into chosen 8-bit timeslots of one serial TDM output stream. Every other timeslot passes through the byte that the switching datapath supplies. Each timeslot begins with a channel strobe. In that cycle the block receives the switched byte and the 3-bit mode code that connection memory holds for the channel. It then sends eight bits, one per clock, MSB first.

A timeslot carries the pattern only when three conditions hold: the test is running, the channel's mode code is the test-pattern code, and the selected test stream number equals this instance's stream number. The generator shifts only while it sends pattern bits. A block of consecutive test channels can therefore start at any channel and span from one channel to a whole frame, and the sequence stays unbroken from one frame to the next. Stopping the test freezes the generator. Starting it again loads the seed.

Top module: `ber_slot_tx`

## Requirements
- R1: While reset is low and right after reset, `tx_bit` is 0, no timeslot is active, and the generator holds the all-ones seed 15'h7FFF.
- R2: The generator implements x^15 + x^14 + 1. The pattern bit is state bit 14. Each step shifts the state left and feeds in bit14 XOR bit13. The emitted bits therefore satisfy o[n+15] = o[n] XOR o[n+1], repeat with period 32767, and the state is never all zeros.
- R3: A timeslot carries the pattern when, in its `chan_sync` cycle, `ber_run` is 1, `chan_mode` equals 3'b110, and `ber_stream` equals the parameter STREAM_ID.
- R4: A timeslot is sent as pass-through data if, in its `chan_sync` cycle, `ber_run` is 0, `chan_mode` is any value other than 3'b110, or `ber_stream` differs from STREAM_ID.
- R5: A `chan_sync` pulse in cycle t makes cycles t+1 to t+8 the timeslot's eight bit periods.
- R6: In a pass-through timeslot, `tx_bit` carries the `sw_byte` captured at `chan_sync`, bit 7 first and bit 0 last.
- R7: If eight bits have gone out and no new `chan_sync` has arrived, `tx_bit` is 0 until the next pulse. A `chan_sync` inside a timeslot ends that timeslot and starts a new one.
- R8: A rising edge of `ber_run` reloads the seed. The first 15 pattern bits after that edge are all 1. The reload takes priority over a step in the same cycle.
- R9: The generator steps exactly once per pattern bit it sends. It holds its state during pass-through slots, during idle periods and while the test is stopped, so the sequence continues unbroken across consecutive test slots and frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ber_run | input | 1 | Test run control, rising edge reseeds |
| ber_stream | input | STREAM_W | Stream number selected for the test pattern |
| chan_sync | input | 1 | Timeslot start strobe |
| chan_mode | input | 3 | Connection-memory mode code of the starting channel |
| sw_byte | input | 8 | Switched data byte of the starting channel |
| tx_bit | output | 1 | Serial output of this stream |

## Verification
Assertions check on every cycle that the generator state is never zero, that it holds whenever it neither steps nor reseeds, that a reseed lands on the seed, that a channel strobe opens a timeslot at bit 0, and that a timeslot closes after its last bit. Only the bench's scenarios show the following: that the emitted bit values follow the recurrence and repeat after 32767 bits, that pass-through bytes come out MSB first, and that the sequence continues across frames and gaps. The stream-mismatch, stopped-test and early-strobe cases are covered the same way.

// File: rtl/ber_tx_pkg.sv
package ber_tx_pkg;
  localparam int LFSR_W   = 15;
  localparam int TAP_HI   = 14;
  localparam int TAP_LO   = 13;
  localparam int MODE_W   = 3;
  localparam logic [MODE_W-1:0] MODE_BER = 3'b110;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 15'h7FFF;

  typedef logic [LFSR_W-1:0] lfsr_t;

  // one shift of the x^15 + x^14 + 1 Fibonacci register
  function automatic lfsr_t lfsr_next(input lfsr_t s);
    return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  function automatic logic lfsr_out(input lfsr_t s);
    return s[LFSR_W-1];
  endfunction
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import ber_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reseed,
  input  logic step,
  output logic pat_bit
);
  lfsr_t state;

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= LFSR_SEED;
    else if (reseed) state <= LFSR_SEED;
    else if (step)   state <= lfsr_next(state);
  end

  assign pat_bit = lfsr_out(state);

  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !reseed) |=> $stable(state));
  a_r8_reseed_loads_seed: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> state == LFSR_SEED);
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import ber_tx_pkg::*;
#(
  parameter int CH_BITS   = 8,
  parameter int STREAM_W  = 5,
  parameter int STREAM_ID = 3,
  localparam int IDX_W    = $clog2(CH_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ber_run,
  input  logic [STREAM_W-1:0] ber_stream,
  input  logic                chan_sync,
  input  logic [MODE_W-1:0]   chan_mode,
  output logic                busy,
  output logic                slot_ber,
  output logic                run_rise
);
  logic [IDX_W-1:0] bit_idx;
  logic             run_q;
  logic             sel_ber;
  logic             last_bit;

  assign sel_ber  = ber_run && (chan_mode == MODE_BER) &&
                    (ber_stream == STREAM_W'(STREAM_ID));
  assign last_bit = (bit_idx == IDX_W'(CH_BITS - 1));
  assign run_rise = ber_run && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      slot_ber <= 1'b0;
      bit_idx  <= '0;
      run_q    <= 1'b0;
    end else begin
      run_q <= ber_run;
      if (chan_sync) begin
        busy     <= 1'b1;
        slot_ber <= sel_ber;
        bit_idx  <= '0;
      end else if (busy) begin
        if (last_bit) begin
          busy     <= 1'b0;
          slot_ber <= 1'b0;
          bit_idx  <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  a_r5_sync_opens_slot: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sync |=> (busy && bit_idx == '0));
  a_r7_slot_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_bit && !chan_sync) |=> !busy);
  a_r4_stopped_no_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sync && !ber_run) |=> !slot_ber);
endmodule

// File: rtl/slot_serializer.sv
module slot_serializer #(
  parameter int CH_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CH_BITS-1:0] din,
  input  logic               busy,
  input  logic               slot_ber,
  input  logic               pat_bit,
  output logic               tx_bit
);
  logic [CH_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= din;
    else if (busy) shreg <= {shreg[CH_BITS-2:0], 1'b0};
  end

  assign tx_bit = busy ? (slot_ber ? pat_bit : shreg[CH_BITS-1]) : 1'b0;

  a_r6_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> shreg == $past(din));
endmodule

// File: rtl/ber_slot_tx.sv
module ber_slot_tx
  import ber_tx_pkg::*;
#(
  parameter int CH_BITS   = 8,
  parameter int STREAM_W  = 5,
  parameter int STREAM_ID = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ber_run,
  input  logic [STREAM_W-1:0] ber_stream,
  input  logic                chan_sync,
  input  logic [2:0]          chan_mode,
  input  logic [7:0]          sw_byte,
  output logic                tx_bit
);
  logic busy, slot_ber, run_rise, pat_bit, pat_step;

  assign pat_step = busy && slot_ber;

  slot_ctrl #(.CH_BITS(CH_BITS), .STREAM_W(STREAM_W), .STREAM_ID(STREAM_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ber_run(ber_run), .ber_stream(ber_stream),
    .chan_sync(chan_sync), .chan_mode(chan_mode),
    .busy(busy), .slot_ber(slot_ber), .run_rise(run_rise)
  );

  prbs_gen u_prbs (
    .clk(clk), .rst_n(rst_n), .reseed(run_rise), .step(pat_step), .pat_bit(pat_bit)
  );

  slot_serializer #(.CH_BITS(CH_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(chan_sync), .din(sw_byte),
    .busy(busy), .slot_ber(slot_ber), .pat_bit(pat_bit), .tx_bit(tx_bit)
  );

  a_r1_idle_output_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_bit);
endmodule

// File: tb/tb_ber_slot_tx.sv
`timescale 1ns/1ps
module tb_ber_slot_tx;
  localparam int ID = 3;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ber_run, chan_sync, tx_bit;
  logic [4:0] ber_stream;
  logic [2:0] chan_mode;
  logic [7:0] sw_byte;

  ber_slot_tx #(.STREAM_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .ber_run(ber_run), .ber_stream(ber_stream),
    .chan_sync(chan_sync), .chan_mode(chan_mode), .sw_byte(sw_byte), .tx_bit(tx_bit)
  );

  int checks = 0, errors = 0;
  bit m_busy, m_ber, m_runq;
  int m_cnt;
  logic [7:0] m_byte;
  bit pend[$];
  bit hist[$];

  function automatic void m_reseed();
    pend.delete();
    for (int i = 0; i < 15; i++) pend.push_back(1'b1);
    hist.delete();
  endfunction

  task automatic chk(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit rise, adv, b;
    if (!rst_n) begin
      m_busy = 0; m_ber = 0; m_runq = 0; m_cnt = 0; m_reseed();
      return;
    end
    rise = ber_run && !m_runq;
    adv  = m_busy && m_ber;
    if (rise) m_reseed();
    else if (adv) begin
      b = pend.pop_front();
      pend.push_back(b ^ pend[0]);
    end
    if (chan_sync) begin
      m_busy = 1; m_cnt = 0; m_byte = sw_byte;
      m_ber = ber_run && chan_mode == 3'b110 && ber_stream == 5'(ID);
    end else if (m_busy) begin
      if (m_cnt == 7) begin m_busy = 0; m_ber = 0; end
      else m_cnt++;
    end
    m_runq = ber_run;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (!m_busy) chk(tx_bit, 1'b0, "R7 idle");
    else if (m_ber) begin
      chk(tx_bit, pend[0], "R3 R9 pattern bit");
      hist.push_back(tx_bit);
    end else chk(tx_bit, m_byte[7 - m_cnt], "R4 R5 R6 pass-through bit");
  endtask

  task automatic send_chan(logic [2:0] mode, int nbits);
    chan_sync = 1; chan_mode = mode; sw_byte = 8'($urandom);
    cyc();
    chan_sync = 0; chan_mode = 3'($urandom);
    for (int i = 1; i < nbits; i++) cyc();
  endtask

  task automatic frame(int first, int last, int nch);
    for (int c = 0; c < nch; c++)
      send_chan((c >= first && c <= last) ? 3'b110 : 3'(c % 6), 8);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; ber_run = 0; chan_sync = 0; chan_mode = 0; sw_byte = 0;
    ber_stream = 5'(ID);
    repeat (4) cyc();
    chk(tx_bit, 1'b0, "R1 reset output");
    rst_n = 1;
    cyc();
    chk(tx_bit, 1'b0, "R1 after reset");

    // stopped test: every code passes through (R4)
    for (int c = 0; c < 40; c++) send_chan(3'(c % 8), 8);

    // start: channels 5..9 carry pattern, three frames (R3, R9, R8)
    ber_run = 1;
    for (int f = 0; f < 3; f++) frame(5, 9, 32);
    for (int i = 0; i < 15; i++) chk(hist[i], 1'b1, "R8 seed bits");

    // wrong stream (R4)
    ber_stream = 5'(ID + 1);
    frame(0, 31, 32);
    ber_stream = 5'(ID);

    // stop then restart (R9 hold, R8 reseed)
    ber_run = 0;
    frame(0, 31, 8);
    ber_run = 1;
    frame(2, 4, 8);
    for (int i = 0; i < 15; i++) chk(hist[i], 1'b1, "R8 seed after restart");

    // gaps and early strobe (R7)
    send_chan(3'b110, 8);
    repeat (12) cyc();
    send_chan(3'b001, 3);
    send_chan(3'b110, 5);
    send_chan(3'b010, 8);
    repeat (3) cyc();

    // long run over all channels for the period (R2)
    ber_run = 0; cyc(); ber_run = 1;
    for (int c = 0; c < 4200; c++) send_chan(3'b110, 8);
    if (hist.size() < 32767 + 200) begin
      errors++;
      $display("FAIL R2 too few bits: got %0d expected %0d", hist.size(), 32967);
    end else
      for (int i = 0; i < 200; i++) chk(hist[i + 32767], hist[i], "R2 period");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule